// File: doc/BRIEF.md
# Bus-Synchronized Real-Time Counter with Shadowed Seconds

This block is a real-time counter peripheral that sits on a simple memory-mapped register bus. It counts milliseconds and seconds from a slow-clock tick enable that runs at about 32 kHz. A prescaler divides that tick down to a millisecond step. The live counters run on the slow side. At a fixed cadence of eight slow ticks, their values are copied into bus-side registers. During the slow-tick period that ends in that copy, the block reports itself busy.

Software reads the time by reading milliseconds first. That same access captures the bus-side seconds into a shadow register, so a later read of the shadow gives seconds that belong to the milliseconds value already returned. Software may read at any time, but a write made while the block is busy is discarded.

There are two seconds alarms and one milliseconds alarm. Each one raises its own bit in a write-one-to-clear status register. A mask register selects which status bits drive the active-high level interrupt.

Top module: `rtc_shadow_timer`

## Requirements
- R1: After reset, every counter, bus-side copy, shadow, alarm value, mask and status bit is 0, the busy bit reads 0 and `irq` is low.
- R2: Milliseconds advance by one every `TICKS_PER_MS` slow ticks and count 0 to 999; the step from 999 returns them to 0 and adds one to seconds.
- R3: Offset 0x004 reads 1 in bit 0 during the last of every eight slow-tick periods and 0 otherwise; the slow tick that ends the busy period copies the live seconds and milliseconds to the bus side (seconds at 0x008, milliseconds at 0x010).
- R4: A bus write made while busy reads 1 changes no register; reads are served at all times.
- R5: A read of milliseconds (0x010) stores the bus-side seconds into the shadow register at 0x00C, which then holds that value until the next milliseconds read.
- R6: Writing seconds (0x008) loads both live and bus-side seconds, clears both millisecond counts and restarts the millisecond prescaler.
- R7: Seconds alarms at 0x014 and 0x018 set status bit 0 and bit 1, and the milliseconds alarm at 0x01C sets status bit 2, on the cycle after the bus-side count first becomes equal to a nonzero alarm value. This happens whatever the mask holds. An alarm value of 0 never sets its bit.
- R8: Writing to status (0x02C) clears every bit written as 1; an alarm setting a bit in the same cycle wins over the clear.
- R9: `irq` is high exactly while some status bit and the same bit of the mask (0x028, layout as status) are both 1.
- R10: Bits 3 and above of mask and status read 0; offsets outside the map read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_rd | input | 1 | Read strobe (side effect: shadow capture) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, active high |

## Verification
A wrong prescaler or counter shows up as a wrong millisecond or seconds read, but only after the next copy, so it is up to eight slow ticks late. A long run of 32 000 ticks across a seconds boundary exposes off-by-one errors in the wrap. A stuck phase counter appears at once on the busy bit, and it also lets a write through that should have been dropped. A broken shadow capture shows up when milliseconds are read, the next copy is allowed to move seconds, and the shadow is read afterwards. Faults in the edge detection, clear priority or masking of the alarms show up within a cycle or two on the status read and on `irq`.

// File: rtl/rtc_regmap_pkg.sv
// Register offsets and shared widths of the shadow-read real-time counter.
// Assumes byte offsets on a 32-bit register bus.
package rtc_regmap_pkg;
    localparam int REG_W          = 32;
    localparam int OFF_BUSY       = 'h004;
    localparam int OFF_SEC        = 'h008;
    localparam int OFF_SHADOW     = 'h00C;
    localparam int OFF_MSEC       = 'h010;
    localparam int OFF_SALM_BASE  = 'h014;   // seconds alarms, stride 4
    localparam int OFF_MSALM      = 'h01C;
    localparam int OFF_MASK       = 'h028;
    localparam int OFF_STATUS     = 'h02C;
endpackage

// File: rtl/rtc_timebase.sv
// Slow-side time base: divides the slow tick into millisecond steps, keeps
// live milliseconds and seconds, and runs the eight-phase copy cadence that
// publishes the live counts into bus-side registers.
// Assumes load_en is only raised while busy is low (the top gates it).
module rtc_timebase #(
    parameter int TICKS_PER_MS = 32,
    parameter int MS_PER_SEC   = 1000,
    parameter int BUSY_PERIOD  = 8,
    parameter int SEC_W        = 32,
    parameter int MS_W         = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output logic             busy,
    output logic [SEC_W-1:0] bus_sec,
    output logic [MS_W-1:0]  bus_ms
);
    localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam int PH_W  = (BUSY_PERIOD > 1) ? $clog2(BUSY_PERIOD) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(BUSY_PERIOD - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_PER_SEC - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PH_W-1:0]  phase_q;
    logic [MS_W-1:0]  live_ms;
    logic [SEC_W-1:0] live_sec;
    logic             ms_step;
    logic             copy_now;

    assign ms_step  = slow_tick && !load_en && (pre_q == PRE_LAST);
    assign busy     = (phase_q == PH_LAST);
    assign copy_now = slow_tick && busy;

    // Millisecond prescaler, restarted by a seconds load.
    always_ff @(posedge clk) begin
        if (!rst_n)          pre_q <= '0;
        else if (load_en)    pre_q <= '0;
        else if (slow_tick)  pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
    end

    // Live milliseconds and seconds on the slow side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_ms  <= '0;
            live_sec <= '0;
        end else if (load_en) begin
            live_ms  <= '0;
            live_sec <= load_sec;
        end else if (ms_step) begin
            if (live_ms == MS_LAST) begin
                live_ms  <= '0;
                live_sec <= live_sec + SEC_W'(1);
            end else begin
                live_ms  <= live_ms + MS_W'(1);
            end
        end
    end

    // Copy cadence phase, free running on the slow tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= '0;
        else if (slow_tick) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end

    // Bus-side copies: loaded by software or published at the end of busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_sec <= '0;
            bus_ms  <= '0;
        end else if (load_en) begin
            bus_sec <= load_sec;
            bus_ms  <= '0;
        end else if (copy_now) begin
            bus_sec <= live_sec;
            bus_ms  <= live_ms;
        end
    end

    // R2
    sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_step && live_ms == MS_LAST) |=> (live_ms == '0 && live_sec == $past(live_sec) + SEC_W'(1)));

    // R2
    ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_ms <= MS_LAST);

    // R3
    copy_publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_now |=> (bus_sec == $past(live_sec) && bus_ms == $past(live_ms)));

    // R3
    busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slow_tick) |=> !busy);

    // R4
    load_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !busy);
endmodule

// File: rtl/rtc_alarm_bank.sv
// Alarm compare bank: holds the seconds alarm values and the millisecond
// alarm value and raises a one-cycle hit when the bus-side count first
// becomes equal to a nonzero alarm value. Hit order: seconds alarms at
// indices 0..NUM_SEC_ALARMS-1, millisecond alarm at NUM_SEC_ALARMS.
module rtc_alarm_bank #(
    parameter int SEC_W          = 32,
    parameter int MS_W           = 10,
    parameter int NUM_SEC_ALARMS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_SEC_ALARMS-1:0]            sec_alm_we,
    input  logic                                 ms_alm_we,
    input  logic [SEC_W-1:0]                     wdata,
    input  logic [SEC_W-1:0]                     bus_sec,
    input  logic [MS_W-1:0]                      bus_ms,
    output logic [NUM_SEC_ALARMS-1:0][SEC_W-1:0] sec_alarm_val,
    output logic [MS_W-1:0]                      ms_alarm_val,
    output logic [NUM_SEC_ALARMS:0]              hit
);
    logic [NUM_SEC_ALARMS:0] match;
    logic [NUM_SEC_ALARMS:0] match_q;

    for (genvar g = 0; g < NUM_SEC_ALARMS; g++) begin : g_sec_alarm
        // Seconds alarm value register.
        always_ff @(posedge clk) begin
            if (!rst_n)             sec_alarm_val[g] <= '0;
            else if (sec_alm_we[g]) sec_alarm_val[g] <= wdata;
        end
        assign match[g] = (sec_alarm_val[g] != '0) && (sec_alarm_val[g] == bus_sec);

        // R7
        sec_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_alarm_val[g] == '0) |-> !hit[g]);
    end

    // Millisecond alarm value register.
    always_ff @(posedge clk) begin
        if (!rst_n)         ms_alarm_val <= '0;
        else if (ms_alm_we) ms_alarm_val <= wdata[MS_W-1:0];
    end
    assign match[NUM_SEC_ALARMS] = (ms_alarm_val != '0) && (ms_alarm_val == bus_ms);

    // Previous compare result, for first-equal detection.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= match;
    end

    assign hit = match & ~match_q;

    // R7
    ms_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_alarm_val == '0) |-> !hit[NUM_SEC_ALARMS]);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Interrupt controller: sticky status bits set by alarm hits, cleared by
// writing ones, masked onto a single level-high interrupt. Set beats clear.
module rtc_irq_ctrl #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hit,
    input  logic               mask_we,
    input  logic               status_we,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] status,
    output logic               irq
);
    logic [NUM_SRC-1:0] clr_bits;

    assign clr_bits = status_we ? wdata : '0;

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wdata;
    end

    // Sticky status with write-one-to-clear; a new hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | hit;
    end

    assign irq = |(status & mask);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R7
        hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> status[i]);

        // R8
        w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_we && wdata[i] && !hit[i]) |=> !status[i]);
    end
endmodule

// File: rtl/rtc_shadow_timer.sv
// Top of the shadow-read real-time counter: decodes the register bus,
// gates writes with the busy flag, holds the shadow seconds, and wires the
// time base, alarm bank and interrupt controller together.
// Assumes single-cycle strobes; read data is combinational from bus_addr.
module rtc_shadow_timer
    import rtc_regmap_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int TICKS_PER_MS   = 32,
    parameter int MS_PER_SEC     = 1000,
    parameter int BUSY_PERIOD    = 8,
    parameter int NUM_SEC_ALARMS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int SEC_W   = REG_W;
    localparam int MS_W    = $clog2(MS_PER_SEC);
    localparam int NUM_SRC = NUM_SEC_ALARMS + 1;

    logic                                 busy;
    logic                                 wr_ok;
    logic                                 sec_load;
    logic [SEC_W-1:0]                     bus_sec;
    logic [MS_W-1:0]                      bus_ms;
    logic [SEC_W-1:0]                     shadow_sec;
    logic [NUM_SEC_ALARMS-1:0]            sec_alm_we;
    logic                                 ms_alm_we;
    logic [NUM_SEC_ALARMS-1:0][SEC_W-1:0] sec_alarm_val;
    logic [MS_W-1:0]                      ms_alarm_val;
    logic [NUM_SRC-1:0]                   hit;
    logic [NUM_SRC-1:0]                   mask;
    logic [NUM_SRC-1:0]                   status;
    logic                                 mask_we;
    logic                                 status_we;
    logic                                 ms_read;

    assign wr_ok     = bus_wr && !busy;
    assign sec_load  = wr_ok && (bus_addr == ADDR_W'(OFF_SEC));
    assign ms_alm_we = wr_ok && (bus_addr == ADDR_W'(OFF_MSALM));
    assign mask_we   = wr_ok && (bus_addr == ADDR_W'(OFF_MASK));
    assign status_we = wr_ok && (bus_addr == ADDR_W'(OFF_STATUS));
    assign ms_read   = bus_rd && (bus_addr == ADDR_W'(OFF_MSEC));

    for (genvar g = 0; g < NUM_SEC_ALARMS; g++) begin : g_salm_we
        assign sec_alm_we[g] = wr_ok && (bus_addr == ADDR_W'(OFF_SALM_BASE + 4 * g));
    end

    rtc_timebase #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_PER_SEC   (MS_PER_SEC),
        .BUSY_PERIOD  (BUSY_PERIOD),
        .SEC_W        (SEC_W),
        .MS_W         (MS_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .load_en   (sec_load),
        .load_sec  (bus_wdata),
        .busy      (busy),
        .bus_sec   (bus_sec),
        .bus_ms    (bus_ms)
    );

    rtc_alarm_bank #(
        .SEC_W          (SEC_W),
        .MS_W           (MS_W),
        .NUM_SEC_ALARMS (NUM_SEC_ALARMS)
    ) u_alarms (
        .clk           (clk),
        .rst_n         (rst_n),
        .sec_alm_we    (sec_alm_we),
        .ms_alm_we     (ms_alm_we),
        .wdata         (bus_wdata),
        .bus_sec       (bus_sec),
        .bus_ms        (bus_ms),
        .sec_alarm_val (sec_alarm_val),
        .ms_alarm_val  (ms_alarm_val),
        .hit           (hit)
    );

    rtc_irq_ctrl #(
        .NUM_SRC (NUM_SRC)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .mask_we   (mask_we),
        .status_we (status_we),
        .wdata     (bus_wdata[NUM_SRC-1:0]),
        .mask      (mask),
        .status    (status),
        .irq       (irq)
    );

    // Shadow seconds captured by every milliseconds read.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_sec <= '0;
        else if (ms_read) shadow_sec <= bus_sec;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_BUSY))   bus_rdata = REG_W'(busy);
        if (bus_addr == ADDR_W'(OFF_SEC))    bus_rdata = bus_sec;
        if (bus_addr == ADDR_W'(OFF_SHADOW)) bus_rdata = shadow_sec;
        if (bus_addr == ADDR_W'(OFF_MSEC))   bus_rdata = REG_W'(bus_ms);
        if (bus_addr == ADDR_W'(OFF_MSALM))  bus_rdata = REG_W'(ms_alarm_val);
        if (bus_addr == ADDR_W'(OFF_MASK))   bus_rdata = REG_W'(mask);
        if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = REG_W'(status);
        for (int i = 0; i < NUM_SEC_ALARMS; i++) begin
            if (bus_addr == ADDR_W'(OFF_SALM_BASE + 4 * i)) bus_rdata = sec_alarm_val[i];
        end
    end

    // R5
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_read |=> (shadow_sec == $past(bus_sec)));

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_read |=> $stable(shadow_sec));

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && busy) |=> ($stable(sec_alarm_val) && $stable(ms_alarm_val) && $stable(mask)));

    // R10
    status_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_STATUS) || bus_addr == ADDR_W'(OFF_MASK))
            |-> (bus_rdata[REG_W-1:NUM_SRC] == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && shadow_sec == '0 && status == '0));
endmodule

// File: tb/sim_rtc_shadow_timer.sv
module sim_rtc_shadow_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rtc_shadow_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {write, offset, data, expected read}; slow_tick held low throughout.
    localparam int NVEC = 16;
    localparam logic [76:0] VEC [NVEC] = '{
        {1'b1, 12'h014, 32'h0000_0010, 32'h0},          // R7 alarm0 value
        {1'b0, 12'h014, 32'h0,         32'h0000_0010},
        {1'b1, 12'h018, 32'h0000_0020, 32'h0},          // R7 alarm1 value
        {1'b0, 12'h018, 32'h0,         32'h0000_0020},
        {1'b1, 12'h01C, 32'h0000_03E7, 32'h0},          // R7 ms alarm value
        {1'b0, 12'h01C, 32'h0,         32'h0000_03E7},
        {1'b1, 12'h028, 32'hFFFF_FFFF, 32'h0},          // R10 mask width
        {1'b0, 12'h028, 32'h0,         32'h0000_0007},
        {1'b0, 12'h02C, 32'h0,         32'h0},          // R7 no spurious status
        {1'b1, 12'h020, 32'hDEAD_BEEF, 32'h0},          // R10 unmapped
        {1'b0, 12'h020, 32'h0,         32'h0},
        {1'b1, 12'h008, 32'h0000_1234, 32'h0},          // R6 seconds load
        {1'b0, 12'h008, 32'h0,         32'h0000_1234},
        {1'b0, 12'h010, 32'h0,         32'h0},          // R6 ms cleared
        {1'b0, 12'h00C, 32'h0,         32'h0000_1234},  // R5 shadow
        {1'b0, 12'h004, 32'h0,         32'h0}           // R3 not busy
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic irq_check(input string tag, input logic exp);
        @(negedge clk);
        #2 check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        slow_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 slow_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got hang expected completion");
            finish_run();
        end
    end

    initial begin
        logic [76:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state (zero alarms vs zero seconds must stay quiet: R7)
        read_check("R1 seconds", 12'h008, 32'h0);
        read_check("R1 milliseconds", 12'h010, 32'h0);
        read_check("R1 busy", 12'h004, 32'h0);
        read_check("R1 status", 12'h02C, 32'h0);
        irq_check("R1 irq", 1'b0);

        // Register access vectors
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            if (v[76]) bus_write(v[75:64], v[63:32]);
            else       read_check($sformatf("table[%0d] R5/R6/R7/R10", i), v[75:64], v[31:0]);
        end
        irq_check("R9 mask without status", 1'b0);

        // R3 busy window and R4 write drop
        ticks(7);
        read_check("R3 busy in last phase", 12'h004, 32'h1);
        bus_write(12'h008, 32'h0000_AAAA);
        bus_write(12'h014, 32'h0000_0055);
        read_check("R4 seconds kept", 12'h008, 32'h0000_1234);
        read_check("R4 alarm kept", 12'h014, 32'h0000_0010);
        read_check("R3 busy held without tick", 12'h004, 32'h1);
        ticks(1);
        read_check("R3 busy released", 12'h004, 32'h0);
        read_check("R3 copy of live seconds", 12'h008, 32'h0000_1234);

        // Setup for counting and alarms
        bus_write(12'h028, 32'h0);
        bus_write(12'h02C, 32'hFFFF_FFFF);
        bus_write(12'h014, 32'd101);
        bus_write(12'h018, 32'd101);
        bus_write(12'h008, 32'd100);   // R6 restart prescaler

        // R2 full second; copy at the last tick publishes pre-wrap values
        ticks(32000);
        read_check("R2 ms before wrap", 12'h010, 32'd999);
        read_check("R5 shadow after ms read", 12'h00C, 32'd100);
        read_check("R7 ms alarm status", 12'h02C, 32'h4);
        irq_check("R9 masked status", 1'b0);
        bus_write(12'h028, 32'h4);
        irq_check("R9 unmasked status", 1'b1);

        ticks(8);
        read_check("R2 seconds carried", 12'h008, 32'd101);
        read_check("R5 shadow holds", 12'h00C, 32'd100);
        read_check("R2 ms wrapped", 12'h010, 32'd0);
        read_check("R5 shadow recaptured", 12'h00C, 32'd101);
        read_check("R7 seconds alarms", 12'h02C, 32'h7);

        bus_write(12'h02C, 32'h4);
        read_check("R8 selective clear", 12'h02C, 32'h3);
        irq_check("R9 masked after clear", 1'b0);
        bus_write(12'h028, 32'h2);
        irq_check("R9 alarm1 unmasked", 1'b1);
        bus_write(12'h02C, 32'hFFFF_FFFF);
        read_check("R8 clear all, R7 no re-set while equal", 12'h02C, 32'h0);
        irq_check("R9 low after clear", 1'b0);
        bus_write(12'h028, 32'h18);
        read_check("R10 reserved mask bits", 12'h028, 32'h0);

        // R1 reset mid-run
        bus_write(12'h028, 32'h7);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        read_check("R1 seconds after reset", 12'h008, 32'h0);
        read_check("R1 mask after reset", 12'h028, 32'h0);
        read_check("R1 alarm after reset", 12'h018, 32'h0);

        finished = 1'b1;
        finish_run();
    end
endmodule